// File: doc/BRIEF.md
# Processor Tick Timer

This block is a cycle-counting tick timer that sits in a processor's special-purpose register space. It holds two 32-bit registers. The count register advances by one each clock. The mode register holds a 28-bit period, an interrupt enable bit, a sticky interrupt pending bit and a two-bit mode field. Each cycle the low 28 bits of the count are compared with the period. When they are equal, the mode field picks what happens next: the count holds, restarts from zero, stops at the period, or keeps running.

Software reaches both registers through a single-cycle write port and a combinational read port. A register select bit picks the register: 0 for the count, 1 for the mode. The interrupt request goes to the core, and it is gated by an external timer-exception-enable input. Software clears a pending interrupt by rewriting the mode register, because a mode write always clears the pending bit.

Top module: `tick_timer`

## Requirements
- R1: After reset the count and mode registers both read as zero, and irq_o is low.
- R2: With mode field 00 (off), the count does not change except through a count write.
- R3: With mode field 01 (restart), a cycle where count[27:0] equals the period makes the next count zero; counting then resumes from zero.
- R4: With mode field 10 (one-shot), a match loads the count with the zero-extended period and freezes it. The count stays frozen until the next mode write.
- R5: With mode field 11 (continuous), a match leaves the count running, and the count rolls over from 0xFFFFFFFF to 0.
- R6: Only count[27:0] is compared with the period, so a match occurs whatever count[31:28] holds.
- R7: A match while interrupt enable (mode bit 29) is 1 sets the pending bit (mode bit 28). The pending bit then stays set until a mode write. With enable at 0, the pending bit is not set.
- R8: A mode write always clears the pending bit, even when bit 28 of the written data is 1.
- R9: irq_o is high in exactly those cycles where the pending bit is set and tee_i is high.
- R10: A count write loads the written value, and match detection continues from that value.
- R11: A mode write with mode field 11 and a period equal to the current count, zero-extended, leaves the count stopped at that value until the next mode write.
- R12: A mode write does not change the count in its own cycle. Mode register reads return {mode[31:30], enable[29], pending[28], period[27:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 mode |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 count, 1 mode |
| rd_data_o | output | 32 | Read data (combinational) |
| tee_i | input | 1 | Timer exception enable from the core |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The assertions assume that write strobe, select and data are never X after reset. They also rely on the single select bit, so a count write and a mode write can never fall in the same cycle; the properties lean on that exclusivity when they name which update wins. The random stimulus draws every input from defined values and issues at most one write per cycle. It keeps periods small or close to the current count, so that matches, restarts and one-shot stops come up often inside a few thousand cycles.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tick_mode_e;
endpackage

// File: rtl/tick_match.sv
module tick_match #(
  parameter int PER_W = 28
) (
  input  logic [PER_W-1:0] cnt_low_i,
  input  logic [PER_W-1:0] period_i,
  output logic             hit_o
);
  assign hit_o = (cnt_low_i == period_i);
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PER_W = DATA_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] cnt_i,
  output tick_mode_e        mode_o,
  output logic              ie_o,
  output logic              ip_o,
  output logic [PER_W-1:0]  period_o,
  output logic              stopped_o
);
  tick_mode_e       wr_mode;
  logic [DATA_W-1:0] wr_per_ext;

  assign wr_mode    = tick_mode_e'(wdata_i[DATA_W-1 -: 2]);
  assign wr_per_ext = {{(DATA_W-PER_W){1'b0}}, wdata_i[PER_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_OFF;
      ie_o      <= 1'b0;
      ip_o      <= 1'b0;
      period_o  <= '0;
      stopped_o <= 1'b0;
    end else if (mode_we_i) begin
      mode_o    <= wr_mode;
      ie_o      <= wdata_i[DATA_W-3];
      ip_o      <= 1'b0;  // software can only clear pending
      period_o  <= wdata_i[PER_W-1:0];
      stopped_o <= (wr_mode == MODE_CONT) && (cnt_i == wr_per_ext);
    end else begin
      if (hit_i && ie_o) ip_o <= 1'b1;
      if (mode_o == MODE_ONESHOT && hit_i && !stopped_o && !cnt_we_i)
        stopped_o <= 1'b1;
    end
  end

  assert_wr_clears_ip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> !ip_o);
  assert_ip_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_o && !mode_we_i) |=> ip_o);
  assert_ip_needs_ie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ip_o && !ie_o) |=> !ip_o);
  assert_stop_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && !mode_we_i) |=> stopped_o);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PER_W = DATA_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_we_i,
  input  logic              mode_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  tick_mode_e        mode_i,
  input  logic              stopped_i,
  input  logic              hit_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [DATA_W-1:0] cnt_o
);
  localparam int UP_W = DATA_W - PER_W;

  logic [DATA_W-1:0] cnt_inc;
  assign cnt_inc = cnt_o + DATA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_we_i) begin
      cnt_o <= wdata_i;
    end else if (!mode_we_i) begin
      unique case (mode_i)
        MODE_OFF:     cnt_o <= cnt_o;
        MODE_RESTART: cnt_o <= hit_i ? '0 : cnt_inc;
        MODE_ONESHOT: begin
          if (stopped_i)  cnt_o <= cnt_o;
          else if (hit_i) cnt_o <= {{UP_W{1'b0}}, period_i};
          else            cnt_o <= cnt_inc;
        end
        MODE_CONT:    cnt_o <= stopped_i ? cnt_o : cnt_inc;
        default:      cnt_o <= cnt_o;
      endcase
    end
  end

  assert_off_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !cnt_we_i) |=> $stable(cnt_o));
  assert_restart_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RESTART && hit_i && !cnt_we_i && !mode_we_i) |=> cnt_o == '0);
  assert_oneshot_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && hit_i && !stopped_i && !cnt_we_i && !mode_we_i)
      |=> (cnt_o[DATA_W-1:PER_W] == '0 && cnt_o[PER_W-1:0] == period_i && stopped_i));
  assert_cont_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && !stopped_i && !cnt_we_i && !mode_we_i)
      |=> cnt_o == $past(cnt_o) + DATA_W'(1));
  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i));
  assert_mode_wr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> $stable(cnt_o));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tee_i,
  output logic              irq_o
);
  localparam int PER_W = DATA_W - 4;

  logic              cnt_we, mode_we, hit, ie, ip, stopped;
  logic [DATA_W-1:0] cnt;
  logic [PER_W-1:0]  period;
  tick_mode_e        mode;

  assign cnt_we  = wr_en_i && !wr_sel_i;
  assign mode_we = wr_en_i &&  wr_sel_i;

  tick_match #(.PER_W(PER_W)) u_match (
    .cnt_low_i (cnt[PER_W-1:0]),
    .period_i  (period),
    .hit_o     (hit)
  );

  tick_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_we_i (mode_we),
    .cnt_we_i  (cnt_we),
    .wdata_i   (wr_data_i),
    .hit_i     (hit),
    .cnt_i     (cnt),
    .mode_o    (mode),
    .ie_o      (ie),
    .ip_o      (ip),
    .period_o  (period),
    .stopped_o (stopped)
  );

  tick_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_we_i  (cnt_we),
    .mode_we_i (mode_we),
    .wdata_i   (wr_data_i),
    .mode_i    (mode),
    .stopped_i (stopped),
    .hit_i     (hit),
    .period_i  (period),
    .cnt_o     (cnt)
  );

  assign rd_data_o = rd_sel_i ? {mode, ie, ip, period} : cnt;
  assign irq_o     = ip && tee_i;

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tee_i);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0, tee_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  string cur_req = "R1";

  logic [31:0] m_cnt;
  logic [27:0] m_per;
  logic [1:0]  m_mode;
  logic        m_ie, m_ip, m_stop;

  always #2 clk_i = ~clk_i;

  tick_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .tee_i(tee_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference step from the requirements, one clock edge
  task automatic model_step(input logic we, input logic sel, input logic [31:0] wd);
    logic hit;
    hit = (m_cnt[27:0] == m_per);
    if (we && sel) begin
      m_stop = (wd[31:30] == 2'b11) && (m_cnt == {4'h0, wd[27:0]});
      m_mode = wd[31:30]; m_ie = wd[29]; m_ip = 1'b0; m_per = wd[27:0];
    end else begin
      if (hit && m_ie) m_ip = 1'b1;
      if (we) m_cnt = wd;
      else case (m_mode)
        2'b01: m_cnt = hit ? 32'h0 : m_cnt + 1;
        2'b10: if (!m_stop) begin
                 if (hit) begin m_cnt = {4'h0, m_per}; m_stop = 1'b1; end
                 else m_cnt = m_cnt + 1;
               end
        2'b11: if (!m_stop) m_cnt = m_cnt + 1;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic we, input logic sel, input logic [31:0] wd,
                     input logic rs, input logic tee);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = wd; rd_sel_i = rs; tee_i = tee;
    @(posedge clk_i);
    model_step(we, sel, wd);
    @(negedge clk_i);
    n_cyc++;
    wr_en_i = 1'b0;
    chk(cur_req, rd_data_o, rs ? {m_mode, m_ie, m_ip, m_per} : m_cnt);
    chk({cur_req, " irq"}, {31'h0, irq_o}, {31'h0, m_ip && tee});
  endtask

  task automatic idle(input int n, input logic tee);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, i[0], tee);
  endtask

  task automatic peek_cnt(input string req, input logic [31:0] exp);
    rd_sel_i = 1'b0; #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'd1234);
    m_cnt = '0; m_per = '0; m_mode = '0; m_ie = 0; m_ip = 0; m_stop = 0;
    #1;
    rd_sel_i = 1'b0; #1; chk("R1 cnt", rd_data_o, 32'h0);
    rd_sel_i = 1'b1; #1; chk("R1 mode", rd_data_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    cur_req = "R2"; idle(4, 1'b1);
    peek_cnt("R2 hold", 32'h0);

    cur_req = "R10"; cyc(1'b1, 1'b0, 32'h0000_1234, 1'b0, 1'b1);
    peek_cnt("R10 load", 32'h0000_1234);
    cur_req = "R12"; cyc(1'b1, 1'b1, {2'b01, 1'b1, 1'b1, 28'h0000_1238}, 1'b1, 1'b1);
    peek_cnt("R12 hold on mode write", 32'h0000_1234);
    cur_req = "R3"; idle(4, 1'b1);
    peek_cnt("R3 at period", 32'h0000_1238);
    idle(1, 1'b1);
    peek_cnt("R3 restart", 32'h0);
    chk("R7 pending", {31'h0, irq_o}, 32'h1);
    cur_req = "R9"; idle(2, 1'b0);
    chk("R9 gated", {31'h0, irq_o}, 32'h0);
    cur_req = "R8"; cyc(1'b1, 1'b1, {2'b00, 1'b0, 1'b1, 28'h5}, 1'b1, 1'b1);
    chk("R8 cleared", rd_data_o, {2'b00, 1'b0, 1'b0, 28'h5});

    cur_req = "R4"; cyc(1'b1, 1'b0, 32'hF000_0000, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, {2'b10, 1'b0, 1'b0, 28'h3}, 1'b0, 1'b1);
    idle(8, 1'b1);
    peek_cnt("R4 frozen", 32'h0000_0003);
    chk("R7 no ie", {31'h0, irq_o}, 32'h0);

    cur_req = "R5"; cyc(1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'hFFF_FFFF}, 1'b0, 1'b1);
    idle(3, 1'b1);
    peek_cnt("R5 wrap", 32'h0000_0001);
    chk("R5 ip at match", {31'h0, irq_o}, 32'h1);

    cur_req = "R6"; cyc(1'b1, 1'b0, 32'h3000_0002, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'h5}, 1'b0, 1'b1);
    idle(2, 1'b1);
    chk("R6 no hit yet", {31'h0, irq_o}, 32'h0);
    idle(2, 1'b1);
    chk("R6 hit low bits", {31'h0, irq_o}, 32'h1);

    cur_req = "R11"; cyc(1'b1, 1'b1, '0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 32'h0000_0007, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, {2'b11, 1'b1, 1'b0, 28'h7}, 1'b0, 1'b1);
    idle(5, 1'b1);
    peek_cnt("R11 stopped", 32'h0000_0007);

    cur_req = "R7 random";
    for (int i = 0; i < 4000; i++) begin
      logic we, sel;
      we = ($urandom_range(0, 15) == 0);
      sel = $urandom_range(0, 2) != 0;
      if (sel) begin
        v = $urandom;
        if (v[0]) v[27:0] = m_cnt[27:0] + 28'($urandom_range(0, 30));
        else      v[27:0] = 28'($urandom_range(0, 40));
      end else begin
        v = $urandom_range(0, 3) == 0 ? 32'hFFFF_FFF0 + $urandom_range(0, 15)
                                      : $urandom_range(0, 40);
      end
      cyc(we, sel, v, 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule